// File: doc/BRIEF.md
# Display Link Transmitter Control and Status Register Bank

This block is the register front end of a display link transmitter core. A host reaches it over a plain 32-bit register bus. The bus has an address, a write enable, write data and a read data path that follows the address with no wait cycle. The block holds the global configuration word, an interrupt enable mask, sticky interrupt status with a write-one-to-clear port, a general status word, four active-video window bounds and three default channel colours. The colour registers supply the pixel value sent while video is blanked.

The core, the PHY and the timing generator report events as single-cycle pulses. The block captures each one into a sticky bit, masks the bits with the enable register and drives one level interrupt line. It also runs a soft-reset handshake. When the host sets the reset request in the configuration word, the handshake is acknowledged only while a separate audio-domain clock is reported running. The acknowledge sets a status bit and raises the soft-reset interrupt. That interrupt shares the host's wait path with the lock event.

Top module: `vidtx_csr`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, `cfg_word`, `win_bounds` and `dflt_colour` are 0 and both FIFO clear strobes are low.
- R2: Offset 0x000 holds the configuration word. It keeps only bit 0 (device enable), bit 1 (HDMI rather than DVI), bit 4 (negative horizontal sync), bit 6 (negative vertical sync) and bit 31 (soft-reset request). These bits read back, appear on `cfg_word`, and every other bit reads 0.
- R3: Writing 1 to configuration bit 12 or bit 13 makes `fifo_ovr_clr` or `fifo_und_clr` (respectively) high for exactly the one cycle after the write edge. Both bits read back as 0.
- R4: Offset 0x004 is the interrupt enable. Bits 1, 3, 4, 5, 6, 7 and 11 are writable. All other bits read 0.
- R5: A pulse on `evt_pulse[k]` sets status bit 3, 4, 5, 6, 7 or 11 for k = 0 to 5 (pixel capture, hot plug, PLL lock, new frame, control packet, sink termination). The bit is set at the next edge and stays set until cleared. Status reads at offset 0x008, and writes to 0x008 are ignored.
- R6: Writing to offset 0x00C clears every status bit whose write data bit is 1 and leaves the others unchanged. All ones clears every pending event. Offset 0x00C reads 0.
- R7: If an event pulse and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: `irq` is the OR over bits 1 to 11 of status AND enable. Status bit 0 reads the same value.
- R9: General status at offset 0x010 has bit 1 set one cycle after configuration bit 31 and `aud_clk_run` are both 1. It drops one cycle after either of them drops. Each rise sets status bit 1.
- R10: Offsets 0x100, 0x104, 0x108 and 0x10C hold X minimum, X maximum, Y minimum and Y maximum. Each keeps the low WIN_W (16) bits and drives slice k of `win_bounds` (k = 0 to 3, lowest slice first).
- R11: Offsets 0x110, 0x114 and 0x118 hold the default colours of channels 0 to 2. Each keeps the low CH_W (16) bits and drives slice k of `dflt_colour`.
- R12: Any other offset, including addresses that are not word aligned, reads 0, and writes to it change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | ADDR_W (12) | Byte offset of the access |
| reg_wen | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 6 | Single-cycle event pulses from the core |
| aud_clk_run | input | 1 | Audio-domain clock is running |
| cfg_word | output | 32 | Stored configuration word |
| fifo_ovr_clr | output | 1 | One-cycle FIFO overrun clear strobe |
| fifo_und_clr | output | 1 | One-cycle FIFO underrun clear strobe |
| win_bounds | output | 4*WIN_W | Active window bounds: X min, X max, Y min, Y max |
| dflt_colour | output | 3*CH_W | Blank-time colour for channels 0 to 2 |
| irq | output | 1 | Level interrupt |

## Verification
The event capture is driven three ways. All six sources are pulsed with the mask cleared, which separates capture from masking. A single source is then enabled, which shows that `irq` follows one bit and not the OR of all pending bits. Finally a pulse lands in the same cycle as its own clear, which fixes the priority. The soft-reset handshake is run with the audio clock stopped, started and stopped again, so the status bit is seen to need both conditions and the interrupt bit is seen to stay after the status drops. A long stretch of random writes, reads and sparse pulses, with unmapped and misaligned offsets mixed in, is compared on every clock against a behavioural model. This catches decode aliasing and writes that leak into the wrong register.

// File: rtl/vidtx_csr_pkg.sv
package vidtx_csr_pkg;

  // Fixed byte offsets of the register map.
  localparam int OFS_CFG   = 'h000;
  localparam int OFS_IEN   = 'h004;
  localparam int OFS_ISTA  = 'h008;
  localparam int OFS_ICLR  = 'h00C;
  localparam int OFS_STA   = 'h010;
  localparam int OFS_WIN0  = 'h100;
  localparam int OFS_DFLT0 = 'h110;

  // Configuration word bit positions.
  localparam int CFG_DEV_EN  = 0;
  localparam int CFG_HDMI    = 1;
  localparam int CFG_HS_NEG  = 4;
  localparam int CFG_VS_NEG  = 6;
  localparam int CFG_OVR_CLR = 12;
  localparam int CFG_UND_CLR = 13;
  localparam int CFG_SRST    = 31;

  localparam logic [31:0] CFG_KEEP = (32'd1 << CFG_DEV_EN) | (32'd1 << CFG_HDMI) |
                                     (32'd1 << CFG_HS_NEG) | (32'd1 << CFG_VS_NEG) |
                                     (32'd1 << CFG_SRST);

  // Interrupt bit positions.
  localparam int INT_W     = 12;
  localparam int INT_ANY   = 0;
  localparam int INT_SRST  = 1;
  localparam int EVT_N     = 6;

  localparam logic [INT_W-1:0] INT_SRC_MASK = 12'h8FA;

  // Position in the interrupt word of event input k.
  function automatic int evt_pos(input int k);
    case (k)
      0:       return 3;
      1:       return 4;
      2:       return 5;
      3:       return 6;
      4:       return 7;
      default: return 11;
    endcase
  endfunction

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_IEN,
    SEL_ISTA,
    SEL_ICLR,
    SEL_STA,
    SEL_WIN,
    SEL_DFLT
  } reg_sel_e;

endpackage

// File: rtl/vidtx_csr_rstsync.sv
module vidtx_csr_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/vidtx_csr_decode.sv
module vidtx_csr_decode
  import vidtx_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_WIN  = 4,
  parameter int N_CH   = 3,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (addr == ADDR_W'(OFS_CFG))  sel = SEL_CFG;
    if (addr == ADDR_W'(OFS_IEN))  sel = SEL_IEN;
    if (addr == ADDR_W'(OFS_ISTA)) sel = SEL_ISTA;
    if (addr == ADDR_W'(OFS_ICLR)) sel = SEL_ICLR;
    if (addr == ADDR_W'(OFS_STA))  sel = SEL_STA;
    for (int k = 0; k < N_WIN; k++) begin
      if (addr == ADDR_W'(OFS_WIN0 + 4 * k)) begin
        sel = SEL_WIN;
        idx = IDX_W'(k);
      end
    end
    for (int k = 0; k < N_CH; k++) begin
      if (addr == ADDR_W'(OFS_DFLT0 + 4 * k)) begin
        sel = SEL_DFLT;
        idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/vidtx_csr_evt.sv
module vidtx_csr_evt
  import vidtx_csr_pkg::*;
#(
  parameter int               W        = INT_W,
  parameter logic [W-1:0]     SRC_MASK = INT_SRC_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] sta_o,
  output logic         irq_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;

  // Set has priority over clear in the same cycle.
  always_comb begin
    pend_d = (set_i | (pend_q & ~clr_i)) & SRC_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign irq_o = |(pend_q & en_i & SRC_MASK);
  assign sta_o = {pend_q[W-1:1], irq_o};
endmodule

// File: rtl/vidtx_csr_srst.sv
module vidtx_csr_srst (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic aux_run_i,
  output logic done_o,
  output logic done_evt_o
);
  logic done_q;
  logic done_d;

  always_comb begin
    done_d     = req_i & aux_run_i;
    done_evt_o = done_d & ~done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done_o = done_q;
endmodule

// File: rtl/vidtx_csr.sv
module vidtx_csr
  import vidtx_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WIN_W  = 16,
  parameter int CH_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wen,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [EVT_N-1:0]      evt_pulse,
  input  logic                  aud_clk_run,
  output logic [31:0]           cfg_word,
  output logic                  fifo_ovr_clr,
  output logic                  fifo_und_clr,
  output logic [4*WIN_W-1:0]    win_bounds,
  output logic [3*CH_W-1:0]     dflt_colour,
  output logic                  irq
);
  localparam int N_WIN = 4;
  localparam int N_CH  = 3;
  localparam int IDX_W = 2;

  logic             rst_sn;
  reg_sel_e         sel;
  logic [IDX_W-1:0] idx;

  logic [31:0]      cfg_q, cfg_d;
  logic [INT_W-1:0] ien_q, ien_d;
  logic             ovr_q, ovr_d, und_q, und_d;
  logic [WIN_W-1:0] win_q [N_WIN];
  logic [CH_W-1:0]  ch_q  [N_CH];

  logic [INT_W-1:0] int_set, int_clr, int_sta;
  logic             srst_sta, srst_evt;

  logic wr_cfg, wr_ien, wr_clr;

  vidtx_csr_rstsync #(.STAGES(2)) u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  vidtx_csr_decode #(
    .ADDR_W (ADDR_W),
    .N_WIN  (N_WIN),
    .N_CH   (N_CH),
    .IDX_W  (IDX_W)
  ) u_dec (
    .addr (reg_addr),
    .sel  (sel),
    .idx  (idx)
  );

  assign wr_cfg = reg_wen && (sel == SEL_CFG);
  assign wr_ien = reg_wen && (sel == SEL_IEN);
  assign wr_clr = reg_wen && (sel == SEL_ICLR);

  // Next state of the control registers.
  always_comb begin
    cfg_d = cfg_q;
    ien_d = ien_q;
    ovr_d = 1'b0;
    und_d = 1'b0;
    if (wr_cfg) begin
      cfg_d = reg_wdata & CFG_KEEP;
      ovr_d = reg_wdata[CFG_OVR_CLR];
      und_d = reg_wdata[CFG_UND_CLR];
    end
    if (wr_ien) begin
      ien_d = reg_wdata[INT_W-1:0] & INT_SRC_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cfg_q <= '0;
      ien_q <= '0;
      ovr_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      ien_q <= ien_d;
      ovr_q <= ovr_d;
      und_q <= und_d;
    end
  end

  // Active-video window bound registers.
  for (genvar k = 0; k < N_WIN; k++) begin : g_win
    logic win_we;
    assign win_we = reg_wen && (sel == SEL_WIN) && (idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)     win_q[k] <= '0;
      else if (win_we) win_q[k] <= reg_wdata[WIN_W-1:0];
    end
    assign win_bounds[k*WIN_W +: WIN_W] = win_q[k];
  end

  // Blank-time colour registers.
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic ch_we;
    assign ch_we = reg_wen && (sel == SEL_DFLT) && (idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)    ch_q[k] <= '0;
      else if (ch_we) ch_q[k] <= reg_wdata[CH_W-1:0];
    end
    assign dflt_colour[k*CH_W +: CH_W] = ch_q[k];
  end

  vidtx_csr_srst u_srst (
    .clk        (clk),
    .rst_n      (rst_sn),
    .req_i      (cfg_q[CFG_SRST]),
    .aux_run_i  (aud_clk_run),
    .done_o     (srst_sta),
    .done_evt_o (srst_evt)
  );

  always_comb begin
    int_set           = '0;
    int_set[INT_SRST] = srst_evt;
    for (int k = 0; k < EVT_N; k++) begin
      int_set[evt_pos(k)] = evt_pulse[k];
    end
    int_clr = wr_clr ? reg_wdata[INT_W-1:0] : '0;
  end

  vidtx_csr_evt #(
    .W        (INT_W),
    .SRC_MASK (INT_SRC_MASK)
  ) u_evt (
    .clk   (clk),
    .rst_n (rst_sn),
    .set_i (int_set),
    .clr_i (int_clr),
    .en_i  (ien_q),
    .sta_o (int_sta),
    .irq_o (irq)
  );

  // Read path.
  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CFG:  reg_rdata = cfg_q;
      SEL_IEN:  reg_rdata = 32'(ien_q);
      SEL_ISTA: reg_rdata = 32'(int_sta);
      SEL_STA:  reg_rdata = 32'(srst_sta) << 1;
      SEL_WIN:  reg_rdata = 32'(win_q[idx]);
      SEL_DFLT: reg_rdata = (idx < IDX_W'(N_CH)) ? 32'(ch_q[idx]) : '0;
      default:  reg_rdata = '0;
    endcase
  end

  assign cfg_word     = cfg_q;
  assign fifo_ovr_clr = ovr_q;
  assign fifo_und_clr = und_q;
endmodule

// File: rtl/vidtx_csr_chk.sv
module vidtx_csr_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_sn,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wen,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [5:0]        evt_pulse,
  input logic              aud_clk_run,
  input logic [31:0]       cfg_word,
  input logic              fifo_ovr_clr,
  input logic              irq,
  input logic [11:0]       int_sta,
  input logic [11:0]       int_en,
  input logic              srst_sta
);
  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return (a == ADDR_W'('h000)) || (a == ADDR_W'('h004)) || (a == ADDR_W'('h008)) ||
           (a == ADDR_W'('h00C)) || (a == ADDR_W'('h010)) || (a == ADDR_W'('h100)) ||
           (a == ADDR_W'('h104)) || (a == ADDR_W'('h108)) || (a == ADDR_W'('h10C)) ||
           (a == ADDR_W'('h110)) || (a == ADDR_W'('h114)) || (a == ADDR_W'('h118));
  endfunction

  // R5
  hpd_sets_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    evt_pulse[1] |=> int_sta[4]);

  // R7
  evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (evt_pulse[0] && reg_wen && reg_addr == ADDR_W'('h00C) && reg_wdata[3]) |=> int_sta[3]);

  // R6
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_wen && reg_addr == ADDR_W'('h00C) && reg_wdata[4] && !evt_pulse[1]) |=> !int_sta[4]);

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (int_en == 12'h000) |-> !irq);

  // R9
  srst_cause_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    srst_sta |-> $past(cfg_word[31] && aud_clk_run));

  // R9
  srst_int_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(srst_sta) |-> int_sta[1]);

  // R3
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    fifo_ovr_clr |-> $past(reg_wen && reg_addr == ADDR_W'('h000) && reg_wdata[12]));

  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !is_mapped(reg_addr) |-> (reg_rdata == 32'h0));
endmodule

bind vidtx_csr vidtx_csr_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_sn       (rst_sn),
  .reg_addr     (reg_addr),
  .reg_wen      (reg_wen),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .evt_pulse    (evt_pulse),
  .aud_clk_run  (aud_clk_run),
  .cfg_word     (cfg_word),
  .fifo_ovr_clr (fifo_ovr_clr),
  .irq          (irq),
  .int_sta      (int_sta),
  .int_en       (ien_q),
  .srst_sta     (srst_sta)
);

// File: tb/vidtx_csr_tb_top.sv
module vidtx_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  evt_pulse = '0;
  logic        aud_clk_run = 1'b0;
  logic [31:0] cfg_word;
  logic        fifo_ovr_clr, fifo_und_clr;
  logic [63:0] win_bounds;
  logic [47:0] dflt_colour;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit chk_on  = 1'b0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  vidtx_csr dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wen      (reg_wen),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .evt_pulse    (evt_pulse),
    .aud_clk_run  (aud_clk_run),
    .cfg_word     (cfg_word),
    .fifo_ovr_clr (fifo_ovr_clr),
    .fifo_und_clr (fifo_und_clr),
    .win_bounds   (win_bounds),
    .dflt_colour  (dflt_colour),
    .irq          (irq)
  );

  // Behavioural reference model.
  logic [31:0] m_cfg, m_en, m_sta;
  logic        m_srst, m_ovr, m_und;
  logic [31:0] m_win [4];
  logic [31:0] m_ch  [3];
  int          m_rcnt;
  int          evt_bit [6] = '{3, 4, 5, 6, 7, 11};

  task automatic m_clear();
    m_cfg = 0; m_en = 0; m_sta = 0; m_srst = 0; m_ovr = 0; m_und = 0;
    foreach (m_win[i]) m_win[i] = 0;
    foreach (m_ch[i])  m_ch[i]  = 0;
  endtask

  function automatic logic m_irq();
    return |(m_sta & m_en & 32'h8FA);
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return m_cfg;
      12'h004: return m_en;
      12'h008: return m_sta | 32'(m_irq());
      12'h010: return 32'(m_srst) << 1;
      12'h100: return m_win[0];
      12'h104: return m_win[1];
      12'h108: return m_win[2];
      12'h10C: return m_win[3];
      12'h110: return m_ch[0];
      12'h114: return m_ch[1];
      12'h118: return m_ch[2];
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    case (a)
      12'h000: return "R2";
      12'h004: return "R4";
      12'h008: return "R5";
      12'h00C: return "R6";
      12'h010: return "R9";
      12'h100, 12'h104, 12'h108, 12'h10C: return "R10";
      12'h110, 12'h114, 12'h118: return "R11";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rcnt = 0;
      m_clear();
    end else if (m_rcnt < 2) begin
      m_rcnt++;
      m_clear();
    end else begin
      logic [31:0] set_v, clr_v;
      logic        cond;
      cond  = m_cfg[31] && aud_clk_run;
      set_v = 0;
      if (cond && !m_srst) set_v[1] = 1'b1;
      for (int k = 0; k < 6; k++) if (evt_pulse[k]) set_v[evt_bit[k]] = 1'b1;
      clr_v = (reg_wen && reg_addr == 12'h00C) ? reg_wdata : 0;
      m_sta  = ((m_sta & ~clr_v) | set_v) & 32'h8FA;
      m_srst = cond;
      m_ovr  = reg_wen && reg_addr == 12'h000 && reg_wdata[12];
      m_und  = reg_wen && reg_addr == 12'h000 && reg_wdata[13];
      if (reg_wen) begin
        case (reg_addr)
          12'h000: m_cfg = reg_wdata & 32'h8000_0053;
          12'h004: m_en  = reg_wdata & 32'h8FA;
          12'h100: m_win[0] = reg_wdata & 32'hFFFF;
          12'h104: m_win[1] = reg_wdata & 32'hFFFF;
          12'h108: m_win[2] = reg_wdata & 32'hFFFF;
          12'h10C: m_win[3] = reg_wdata & 32'hFFFF;
          12'h110: m_ch[0] = reg_wdata & 32'hFFFF;
          12'h114: m_ch[1] = reg_wdata & 32'hFFFF;
          12'h118: m_ch[2] = reg_wdata & 32'hFFFF;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // Per-clock comparison with the model.
  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R2 cfg_word", cfg_word, m_cfg);
      chk("R3 fifo_ovr_clr", 32'(fifo_ovr_clr), 32'(m_ovr));
      chk("R3 fifo_und_clr", 32'(fifo_und_clr), 32'(m_und));
      chk("R8 irq", 32'(irq), 32'(m_irq()));
      for (int k = 0; k < 4; k++) chk("R10 win_bounds", 32'(win_bounds[k*16 +: 16]), m_win[k]);
      for (int k = 0; k < 3; k++) chk("R11 dflt_colour", 32'(dflt_colour[k*16 +: 16]), m_ch[k]);
      chk({req_of(reg_addr), " rdata"}, reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    reg_addr = a; reg_wen = 1'b0;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [5:0] v);
    @(negedge clk); #1 evt_pulse = v;
    @(negedge clk); #1 evt_pulse = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fifo strobes", 32'({fifo_ovr_clr, fifo_und_clr}), 0);
    chk("R1 win_bounds", 32'(win_bounds != 0), 0);
    chk("R1 dflt_colour", 32'(dflt_colour != 0), 0);
    foreach (evt_bit[i]) ;
    rd(12'h000, 0, "R1 cfg");
    rd(12'h004, 0, "R1 ien");
    rd(12'h008, 0, "R1 ista");
    rd(12'h010, 0, "R1 sta");
    rd(12'h10C, 0, "R1 win");
    rd(12'h118, 0, "R1 dflt");

    // R3 FIFO clear strobes
    @(negedge clk); #1 reg_addr = 12'h000; reg_wdata = 32'h0000_3000; reg_wen = 1'b1;
    @(negedge clk);
    chk("R3 ovr pulse", 32'(fifo_ovr_clr), 1);
    chk("R3 und pulse", 32'(fifo_und_clr), 1);
    #1 reg_wen = 1'b0;
    @(negedge clk);
    chk("R3 ovr low", 32'(fifo_ovr_clr), 0);
    chk("R3 und low", 32'(fifo_und_clr), 0);
    rd(12'h000, 0, "R3 cfg bits 12/13 read 0");

    // R2 configuration keep mask
    wr(12'h000, 32'hFFFF_CFFF);
    rd(12'h000, 32'h8000_0053, "R2 cfg keep");
    chk("R2 cfg_word port", cfg_word, 32'h8000_0053);
    wr(12'h000, 32'h0000_0012);
    rd(12'h000, 32'h0000_0012, "R2 cfg partial");

    // R4 enable mask
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, 32'h0000_08FA, "R4 ien mask");
    wr(12'h004, 0);

    // R5 capture, R8 masking
    pulse(6'b111111);
    rd(12'h008, 32'h0000_08F8, "R5 all events captured");
    chk("R8 irq masked", 32'(irq), 0);
    wr(12'h004, 32'h10);
    rd(12'h008, 32'h0000_08F9, "R8 status bit0");
    chk("R8 irq on", 32'(irq), 1);

    // R5 writes to status ignored, R6 clear
    wr(12'h008, 0);
    rd(12'h008, 32'h0000_08F9, "R5 status write ignored");
    wr(12'h00C, 32'h10);
    rd(12'h008, 32'h0000_08E8, "R6 single clear");
    chk("R8 irq off after clear", 32'(irq), 0);
    rd(12'h00C, 0, "R6 clear reads 0");
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h008, 0, "R6 clear all");

    // R7 event beats clear
    @(negedge clk); #1;
    evt_pulse = 6'b000010; reg_addr = 12'h00C; reg_wdata = 32'h10; reg_wen = 1'b1;
    @(negedge clk); #1 evt_pulse = '0; reg_wen = 1'b0;
    rd(12'h008, 32'h0000_0011, "R7 event wins");
    wr(12'h00C, 32'hFFFF_FFFF);

    // R9 soft-reset handshake
    wr(12'h000, 32'h8000_0000);
    repeat (3) @(negedge clk);
    rd(12'h010, 0, "R9 no ack without audio clock");
    rd(12'h008, 0, "R9 no int without audio clock");
    @(negedge clk); #1 aud_clk_run = 1'b1;
    rd(12'h010, 32'h2, "R9 ack");
    rd(12'h008, 32'h2, "R9 int bit1 set");
    wr(12'h004, 32'h2);
    chk("R9 irq", 32'(irq), 1);
    @(negedge clk); #1 aud_clk_run = 1'b0;
    rd(12'h010, 0, "R9 ack drops");
    rd(12'h008, 32'h3, "R9 int bit1 sticky");
    wr(12'h000, 0);
    wr(12'h00C, 32'hFFFF_FFFF);

    // R10 window, R11 colours
    wr(12'h100, 32'hABCD_0011);
    wr(12'h104, 32'h1234_0780);
    wr(12'h108, 32'h0000_0029);
    wr(12'h10C, 32'hFFFF_0464);
    rd(12'h104, 32'h0000_0780, "R10 xmax");
    chk("R10 ymax port", 32'(win_bounds[63:48]), 32'h0464);
    wr(12'h110, 32'h0);
    wr(12'h114, 32'h5555_0000);
    wr(12'h118, 32'h0001_0060);
    rd(12'h118, 32'h0000_0060, "R11 ch2");
    chk("R11 ch2 port", 32'(dflt_colour[47:32]), 32'h0060);

    // R12 unmapped offsets
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h11C, 32'hFFFF_FFFF);
    wr(12'h102, 32'hFFFF_FFFF);
    wr(12'h0FC, 32'hFFFF_FFFF);
    rd(12'h020, 0, "R12 unmapped read");
    rd(12'h102, 0, "R12 misaligned read");
    rd(12'h100, 32'h0000_0011, "R12 window untouched");
    rd(12'h000, 0, "R12 cfg untouched");
    rd(12'h004, 32'h2, "R12 ien untouched");

    // Random traffic compared each clock with the model
    for (int n = 0; n < 2000; n++) begin
      logic [11:0] alist [14] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
                                  12'h100, 12'h104, 12'h108, 12'h10C, 12'h110,
                                  12'h114, 12'h118, 12'h024, 12'h106};
      @(negedge clk); #1;
      reg_addr  = alist[$urandom_range(0, 13)];
      reg_wen   = ($urandom_range(0, 3) == 0);
      reg_wdata = $urandom;
      evt_pulse = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h0;
      if ($urandom_range(0, 15) == 0) aud_clk_run = ~aud_clk_run;
    end
    @(negedge clk); #1 reg_wen = 1'b0; evt_pulse = '0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule